// File: doc/BRIEF.md
# UART Channel Sleep and Wake Controller

This block decides when a group of UART channels may stop their baud-rate oscillator and when that oscillator must run again. Each channel reports whether its transmit and receive queues are empty, whether an interrupt is pending, whether its divisor is non-zero, the level of its receive pin, whether it runs in infrared mode, its four modem status bits and a transmit-holding write strobe. The controller combines these into one decision for all channels. Sleep is entered only when every channel is quiet for a fixed qualification window. It leaves sleep on the first wake cause and goes back to sleep by itself once the causes are gone.

The controller runs on an always-on clock. The oscillator it gates is a separate clock domain that the controller does not use. The receive pin and the modem status bits pass through a two-flop synchronizer, and a change on them counts as activity. On each wake the controller raises a per-channel wake indicator. The indicator stays set until that channel's interrupt status is read. While it is set, it counts as a pending interrupt, so the channel cannot go back to sleep before software has seen the wake.

The state machine has four states. `ST_RUN` is awake and idle. `ST_QUAL` is counting the qualification window. `ST_SLEEP` has the oscillator stopped. `ST_WAKE` is a single awake cycle after sleep. The transitions are:
- run→qual when all channels are ready and no wake cause is present.
- qual→run on any break.
- qual→sleep on the last qualified sample.
- sleep→wake on any wake cause.
- wake→run unconditionally.

Top module: `uart_sleep_ctl`

## Requirements
- R1: When every channel is ready for `QUAL_CYC` (default 4) consecutive clock samples, the controller enters sleep on the edge of the last sample, with `sleeping`=1 and `osc_en`=0. A channel is ready when all of these hold: sleep enabled, no pending interrupt, no set wake flag, both queues empty, RX idle, divisor non-zero, and all four synchronized modem bits zero.
- R2: If any one readiness condition is false on any single channel, the controller does not sleep. The conditions include a modem bit set, a queue not empty and an interrupt pending.
- R3: RX idle means the synchronized pin is 1 when `ir_mode`=0 and 0 when `ir_mode`=1.
- R4: A break in readiness, or any wake cause during qualification, restarts the count. After a break, the first sleep comes exactly `QUAL_CYC` edges after readiness returns.
- R5: While sleeping, any of the following on any channel makes the controller leave sleep on the next edge, with `osc_en`=1: sleep enable low, interrupt pending high, a `thr_wr` pulse, or a change of the synchronized RX pin or modem bits.
- R6: On leaving sleep, the controller sets `wake_irq` for every channel. A channel's flag clears on its `isr_rd` pulse. A set in the same cycle as a read wins.
- R7: Once all wake causes are gone and the wake flags are read, the controller re-enters sleep with no other action. The oscillator is stopped for exactly as long as `sleeping`=1.
- R8: The RX pin and the modem bits pass through two synchronizing flops. A pin change applied before edge e1 is seen as a wake cause at edge e3.
- R9: After reset the controller is in `ST_RUN`, with `osc_en`=1, `sleeping`=0 and `wake_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_en | input | NCH | Per-channel sleep enable |
| irq_pend | input | NCH | Per-channel pending interrupt |
| tx_empty | input | NCH | Transmit queue and shifter empty |
| rx_empty | input | NCH | Receive queue empty |
| rx_pin | input | NCH | Raw receive pin level |
| ir_mode | input | NCH | Infrared mode (idle level low) |
| div_nz | input | NCH | Baud divisor non-zero |
| msr_bits | input | NCH*MSR_W | Modem status bits, channel c at [c*MSR_W +: MSR_W] |
| thr_wr | input | NCH | Transmit-holding write strobe |
| isr_rd | input | NCH | Interrupt status read strobe |
| osc_en | output | 1 | Oscillator enable |
| sleeping | output | 1 | Sleep status |
| wake_irq | output | NCH | Per-channel wake indicator interrupt |

## Verification
The controller's outputs are all registered, with this timing:
- A synchronous wake cause such as `thr_wr`, `irq_pend` or `sleep_en` drops `sleeping` one edge after it is applied.
- A pin change drops `sleeping` three edges after it is applied, because of the two synchronizing flops.
- Sleep entry follows the `QUAL_CYC`-th qualified sample.

The bench drives inputs on the falling edge and keeps a behavioural model that moves one step on every rising edge. It compares all outputs at each falling edge. Directed checks count edges from the stimulus and sample midway through the cycle, so each check lands on the cycle its requirement names.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_QUAL  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } slp_state_t;

endpackage

// File: rtl/slp_sync_edge.sv
module slp_sync_edge #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] chg
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q[i] <= 1'b0;
                    sync_q[i] <= 1'b0;
                    hist_q[i] <= 1'b0;
                end else begin
                    meta_q[i] <= din[i];
                    sync_q[i] <= meta_q[i];
                    hist_q[i] <= sync_q[i];
                end
            end
            assign lvl[i] = sync_q[i];
            assign chg[i] = sync_q[i] ^ hist_q[i];
        end
    endgenerate
endmodule

// File: rtl/slp_chan_eval.sv
module slp_chan_eval #(
    parameter int MSR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_en,
    input  logic             irq_pend,
    input  logic             wake_flag,
    input  logic             tx_empty,
    input  logic             rx_empty,
    input  logic             rx_pin,
    input  logic             ir_mode,
    input  logic             div_nz,
    input  logic [MSR_W-1:0] msr,
    input  logic             thr_wr,
    output logic             ready,
    output logic             wake
);
    localparam int SW = MSR_W + 1;

    logic [SW-1:0] s_lvl;
    logic [SW-1:0] s_chg;
    logic          rx_s;
    logic          rx_idle;
    logic [MSR_W-1:0] msr_s;

    slp_sync_edge #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({msr, rx_pin}),
        .lvl   (s_lvl),
        .chg   (s_chg)
    );

    assign rx_s  = s_lvl[0];
    assign msr_s = s_lvl[SW-1:1];

    always_comb begin
        rx_idle = ir_mode ? ~rx_s : rx_s;
        ready   = sleep_en & ~irq_pend & ~wake_flag & tx_empty & rx_empty
                & rx_idle & div_nz & (msr_s == '0);
        wake    = ~sleep_en | irq_pend | thr_wr | (|s_chg);
    end
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
#(
    parameter int QUAL_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_ready,
    input  logic any_wake,
    output logic wake_evt,
    output logic osc_en,
    output logic sleeping
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

    slp_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          qual_ok;

    assign qual_ok = all_ready & ~any_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && qual_ok)
                cnt_q <= CW'(1);
            else if (state_q == ST_QUAL && qual_ok)
                cnt_q <= cnt_q + CW'(1);
            else
                cnt_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = qual_ok ? ST_QUAL : ST_RUN;
            ST_QUAL: begin
                if (!qual_ok)          state_d = ST_RUN;
                else if (cnt_q == LAST) state_d = ST_SLEEP;
                else                   state_d = ST_QUAL;
            end
            ST_SLEEP: state_d = any_wake ? ST_WAKE : ST_SLEEP;
            ST_WAKE:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        osc_en   = (state_q != ST_SLEEP);
        sleeping = (state_q == ST_SLEEP);
        wake_evt = (state_q == ST_SLEEP) && any_wake;
    end
endmodule

// File: rtl/uart_sleep_ctl.sv
module uart_sleep_ctl #(
    parameter int NCH      = 2,
    parameter int MSR_W    = 4,
    parameter int QUAL_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       sleep_en,
    input  logic [NCH-1:0]       irq_pend,
    input  logic [NCH-1:0]       tx_empty,
    input  logic [NCH-1:0]       rx_empty,
    input  logic [NCH-1:0]       rx_pin,
    input  logic [NCH-1:0]       ir_mode,
    input  logic [NCH-1:0]       div_nz,
    input  logic [NCH*MSR_W-1:0] msr_bits,
    input  logic [NCH-1:0]       thr_wr,
    input  logic [NCH-1:0]       isr_rd,
    output logic                 osc_en,
    output logic                 sleeping,
    output logic [NCH-1:0]       wake_irq
);
    logic [NCH-1:0] ready_v;
    logic [NCH-1:0] wake_v;
    logic [NCH-1:0] wflag_q;
    logic           wake_evt;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            slp_chan_eval #(.MSR_W(MSR_W)) u_eval (
                .clk       (clk),
                .rst_n     (rst_n),
                .sleep_en  (sleep_en[c]),
                .irq_pend  (irq_pend[c]),
                .wake_flag (wflag_q[c]),
                .tx_empty  (tx_empty[c]),
                .rx_empty  (rx_empty[c]),
                .rx_pin    (rx_pin[c]),
                .ir_mode   (ir_mode[c]),
                .div_nz    (div_nz[c]),
                .msr       (msr_bits[c*MSR_W +: MSR_W]),
                .thr_wr    (thr_wr[c]),
                .ready     (ready_v[c]),
                .wake      (wake_v[c])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         wflag_q[c] <= 1'b0;
                else if (wake_evt)  wflag_q[c] <= 1'b1;
                else if (isr_rd[c]) wflag_q[c] <= 1'b0;
            end
        end
    endgenerate

    slp_fsm #(.QUAL_CYC(QUAL_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_ready (&ready_v),
        .any_wake  (|wake_v),
        .wake_evt  (wake_evt),
        .osc_en    (osc_en),
        .sleeping  (sleeping)
    );

    assign wake_irq = wflag_q;
endmodule

// File: rtl/slp_checker.sv
module slp_checker #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] sleep_en,
    input logic [NCH-1:0] irq_pend,
    input logic [NCH-1:0] thr_wr,
    input logic [NCH-1:0] isr_rd,
    input logic           sleeping,
    input logic [NCH-1:0] wake_irq
);
    p_entry_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleeping) |-> (&$past(sleep_en)));

    p_entry_no_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleeping) |-> ($past(irq_pend) == '0));

    p_wake_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && (|thr_wr)) |=> !sleeping);

    p_wake_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !(&sleep_en)) |=> !sleeping);

    p_flag_on_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleeping) |-> (&wake_irq));

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chk
            p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (wake_irq[c] && !isr_rd[c]) |=> wake_irq[c]);
        end
    endgenerate
endmodule

bind uart_sleep_ctl slp_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_en (sleep_en),
    .irq_pend (irq_pend),
    .thr_wr   (thr_wr),
    .isr_rd   (isr_rd),
    .sleeping (sleeping),
    .wake_irq (wake_irq)
);

// File: tb/sim_uart_sleep_ctl.sv
`timescale 1ns/1ps
module sim_uart_sleep_ctl;
    localparam int NCH = 2;
    localparam int MW  = 4;
    localparam int Q   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] sleep_en, irq_pend, tx_empty, rx_empty, rx_pin, ir_mode, div_nz, thr_wr, isr_rd;
    logic [NCH*MW-1:0] msr_bits;
    logic osc_en, sleeping;
    logic [NCH-1:0] wake_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_sleep_ctl #(.NCH(NCH), .MSR_W(MW), .QUAL_CYC(Q)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .irq_pend(irq_pend),
        .tx_empty(tx_empty), .rx_empty(rx_empty), .rx_pin(rx_pin), .ir_mode(ir_mode),
        .div_nz(div_nz), .msr_bits(msr_bits), .thr_wr(thr_wr), .isr_rd(isr_rd),
        .osc_en(osc_en), .sleeping(sleeping), .wake_irq(wake_irq)
    );

    // behavioural reference: 0 run, 1 qualify, 2 asleep, 3 waking
    int m_st, m_cnt;
    logic [NCH-1:0] m_flag;
    logic [NCH*(MW+1)-1:0] pipe1, pipe2, pipe3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_flag = '0;
            pipe1 = '0; pipe2 = '0; pipe3 = '0;
        end else begin
            bit all_rdy, any_wk;
            all_rdy = 1; any_wk = 0;
            for (int c = 0; c < NCH; c++) begin
                logic [MW:0] lv, ch;
                logic idle;
                lv = pipe2[c*(MW+1) +: MW+1];
                ch = lv ^ pipe3[c*(MW+1) +: MW+1];
                idle = ir_mode[c] ? !lv[0] : lv[0];
                if (!(sleep_en[c] && !irq_pend[c] && !m_flag[c] && tx_empty[c] && rx_empty[c]
                      && idle && div_nz[c] && lv[MW:1] == 0)) all_rdy = 0;
                if (!sleep_en[c] || irq_pend[c] || thr_wr[c] || ch != 0) any_wk = 1;
            end
            for (int c = 0; c < NCH; c++)
                if (m_st != 2 || !any_wk) if (isr_rd[c]) m_flag[c] = 1'b0;
            case (m_st)
                0: if (all_rdy && !any_wk) begin m_st = 1; m_cnt = 1; end
                1: if (!(all_rdy && !any_wk)) m_st = 0;
                   else if (m_cnt == Q - 1) m_st = 2;
                   else m_cnt++;
                2: if (any_wk) begin m_st = 3; m_flag = '1; end
                default: m_st = 0;
            endcase
            pipe3 = pipe2; pipe2 = pipe1;
            for (int c = 0; c < NCH; c++)
                pipe1[c*(MW+1) +: MW+1] = {msr_bits[c*MW +: MW], rx_pin[c]};
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (sleeping !== (m_st == 2)) begin
                n_bad++;
                $display("FAIL R1 model sleeping act=%0b exp=%0b t=%0t", sleeping, m_st == 2, $time);
            end
            n_chk++;
            if (osc_en !== (m_st != 2)) begin
                n_bad++;
                $display("FAIL R7 model osc_en act=%0b exp=%0b t=%0t", osc_en, m_st != 2, $time);
            end
            n_chk++;
            if (wake_irq !== m_flag) begin
                n_bad++;
                $display("FAIL R6 model wake_irq act=%b exp=%b t=%0t", wake_irq, m_flag, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_isr();
        isr_rd = '1; cyc(1); isr_rd = '0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        sleep_en = '1; irq_pend = '0; tx_empty = '1; rx_empty = '1; rx_pin = '1;
        ir_mode = '0; div_nz = '1; msr_bits = '0; thr_wr = '0; isr_rd = '0;
        cyc(2);
        chk("R9 osc_en", osc_en, 1); chk("R9 sleeping", sleeping, 0); chk("R9 wake_irq", wake_irq, 0);
        rst_n = 1'b1;
        cyc(12);
        chk("R1 sleep entry", sleeping, 1); chk("R1 osc stopped", osc_en, 0);

        thr_wr[1] = 1'b1; cyc(1); thr_wr = '0;
        chk("R5 thr wake", sleeping, 0); chk("R6 flags set", wake_irq, 2'b11);
        cyc(10);
        chk("R7 flag blocks resleep", sleeping, 0);
        read_isr(); cyc(10);
        chk("R7 auto resleep", sleeping, 1);

        rx_pin[0] = 1'b0; cyc(1); rx_pin[0] = 1'b1; cyc(1);
        chk("R8 still asleep after 2 edges", sleeping, 1);
        cyc(1);
        chk("R8 wake after 3 edges", sleeping, 0);
        cyc(3); read_isr(); cyc(10);
        chk("R7 resleep after rx", sleeping, 1);

        msr_bits[MW+2] = 1'b1; cyc(12);
        chk("R5 modem wake", sleeping, 0);
        read_isr(); cyc(10);
        chk("R2 modem bit blocks", sleeping, 0);
        msr_bits = '0; cyc(10);
        chk("R7 resleep after modem", sleeping, 1);

        sleep_en[0] = 1'b0; cyc(1);
        chk("R5 disable wake", sleeping, 0);
        read_isr(); cyc(10);
        chk("R2 disabled blocks", sleeping, 0);
        sleep_en = '1; cyc(10);
        chk("R7 resleep re-enabled", sleeping, 1);

        irq_pend[0] = 1'b1; isr_rd[0] = 1'b1; cyc(1); isr_rd = '0;
        chk("R6 set wins over read", wake_irq[0], 1); chk("R5 irq wake", sleeping, 0);
        ir_mode = '1; irq_pend = '0; read_isr(); cyc(12);
        chk("R3 ir mode high pin not idle", sleeping, 0);
        rx_pin = '0; cyc(14);
        chk("R3 ir mode low pin idle", sleeping, 1);
        irq_pend[1] = 1'b1; cyc(1); irq_pend = '0;
        ir_mode = '0; rx_pin = '1; read_isr(); cyc(14);
        chk("R3 normal mode resleep", sleeping, 1);

        tx_empty[1] = 1'b0; thr_wr[1] = 1'b1; cyc(1); thr_wr = '0;
        read_isr(); cyc(10);
        chk("R2 tx busy blocks", sleeping, 0);
        tx_empty = '1;
        for (int k = 0; k < 4; k++) begin
            cyc(3); div_nz[0] = 1'b0; cyc(1); div_nz[0] = 1'b1;
        end
        chk("R4 broken window", sleeping, 0);
        div_nz[0] = 1'b0; cyc(2); div_nz[0] = 1'b1;
        cyc(Q - 1);
        chk("R4 not yet at Q-1", sleeping, 0);
        cyc(1);
        chk("R4 sleep at Q", sleeping, 1);

        cyc(5);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule